// File: doc/BRIEF.md
# Two-Word Message FIFO Mailbox

This block is the host-facing message port between a control processor and a coprocessor. A single register address carries message traffic both ways. A host write to it pushes one word into the inbound queue, which runs toward the coprocessor. A host read from it pops one word from the outbound queue, which runs toward the host. The coprocessor has its own pop port on the inbound queue and its own push port on the outbound queue. It also has a write port into a shared mailbox register.

A message is two words long. To send, the host checks that the inbound queue is empty, writes the first word, confirms there is still room, writes the second word, and then polls status until the coprocessor has drained the queue. Replies are collected by reading the same address while status shows the outbound queue holds data. Besides the data register, the host sees three more registers: a status register with occupancy and interrupt flags, a control register with interrupt enables, and the mailbox register. The mailbox is cleared from the host side by writing a fixed key. The enabled interrupt flags are ORed onto one interrupt line.

Top module: `msg_mailbox`

## Requirements
- R1: After synchronous reset, both queues are empty, control and mailbox read 0, status reads 0x00060000 and `irq` is low.
- R2: A host write to offset 0 appends `host_wdata` to the inbound queue. `cp_in_data` shows the oldest inbound word, or 0 when the queue is empty. `cp_in_pop` removes that word. Words leave in the order they were written.
- R3: With `host_rd` at offset 0, `host_rdata` shows the oldest outbound word in that cycle and the word is removed at the clock edge. A read of an empty outbound queue returns 0 and changes nothing.
- R4: Each queue holds FIFO_DEPTH words (2 by default). Whether a push or pop is accepted depends on the occupancy before the edge. A push into a full queue is dropped even if a pop happens in the same cycle. A pop from an empty queue does nothing even if a push happens in the same cycle, and the pushed word is kept.
- R5: Status (offset 1) reports queue state in these bits: 16 = outbound not empty, 17 = inbound not full, 18 = outbound not full, 19 = inbound not empty.
- R6: Status bits 20, 21 and 22 are the mailbox, inbound and outbound interrupt flags. Bit 23 and every bit outside 16..22 read 0.
- R7: Control (offset 2) stores only bits 16, 17, 20, 24 and 25 of a host write. All other bits read 0.
- R8: Each interrupt flag is its condition ANDed with its enable, and `irq` is the OR of the three flags. Inbound: inbound not full, enabled by control bit 17 or 25. Outbound: outbound not empty, enabled by control bit 16 or 24. Mailbox: mailbox nonzero, enabled by control bit 20.
- R9: The mailbox (offset 3) loads `cp_mbx_data` when `cp_mbx_wr` is high. A host write of exactly 0x0000F0F0 clears it, and any other host value is ignored. If the coprocessor writes in the same cycle as a host clear, the coprocessor's value is kept.
- R10: A two-word message written by the host, popped by the coprocessor and pushed back unchanged is read by the host as the same two words in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (pops at offset 0) |
| host_addr | input | 2 | Register offset: 0 data, 1 status, 2 control, 3 mailbox |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Addressed register value, combinational |
| cp_in_pop | input | 1 | Coprocessor pops the inbound queue |
| cp_in_data | output | 32 | Oldest inbound word, 0 when empty |
| cp_out_push | input | 1 | Coprocessor pushes the outbound queue |
| cp_out_data | input | 32 | Word pushed to the outbound queue |
| cp_mbx_wr | input | 1 | Coprocessor writes the mailbox |
| cp_mbx_data | input | 32 | Mailbox value from the coprocessor |
| irq | output | 1 | OR of the enabled interrupt flags |

## Verification
Each queue has one writer on each side, so a host push can fall in the same cycle as a coprocessor pop, and a host pop can fall in the same cycle as a coprocessor push. A mailbox clear from the host can also fall in the same cycle as a coprocessor mailbox write. Directed cycles provoke these collisions with the queue full and with the queue empty, and the random phase produces them at every occupancy. In each case the result is judged against a queue model that accepts an operation only on the occupancy seen before the edge. The words that come out afterwards, and the status bits, must match that model.

// File: rtl/msgbox_pkg.sv
package msgbox_pkg;

    localparam int REG_W = 32;

    // status bit positions
    localparam int ST_OUT_NE  = 16;
    localparam int ST_IN_NF   = 17;
    localparam int ST_OUT_NF  = 18;
    localparam int ST_IN_NE   = 19;
    localparam int ST_MBX_IRQ = 20;
    localparam int ST_IN_IRQ  = 21;
    localparam int ST_OUT_IRQ = 22;

    // control bit positions
    localparam int CT_OUT_EN  = 16;
    localparam int CT_IN_EN   = 17;
    localparam int CT_MBX_EN  = 20;
    localparam int CT_OUT_WEN = 24;
    localparam int CT_IN_WEN  = 25;

    localparam logic [REG_W-1:0] CTRL_MASK =
        (REG_W'(1) << CT_OUT_EN)  | (REG_W'(1) << CT_IN_EN) |
        (REG_W'(1) << CT_MBX_EN)  | (REG_W'(1) << CT_OUT_WEN) |
        (REG_W'(1) << CT_IN_WEN);

    localparam logic [REG_W-1:0] MBX_CLEAR_KEY = 32'h0000_F0F0;

    typedef enum logic [1:0] {
        SEL_FIFO = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_MBX  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic in_ne;
        logic out_nf;
        logic in_nf;
        logic out_ne;
    } fifo_flags_t;

    typedef struct packed {
        logic out_irq;
        logic in_irq;
        logic mbx_irq;
    } irq_flags_t;

    function automatic logic [REG_W-1:0] pack_status(input fifo_flags_t f,
                                                     input irq_flags_t q);
        logic [REG_W-1:0] s;
        s = '0;
        s[ST_OUT_NE]  = f.out_ne;
        s[ST_IN_NF]   = f.in_nf;
        s[ST_OUT_NF]  = f.out_nf;
        s[ST_IN_NE]   = f.in_ne;
        s[ST_MBX_IRQ] = q.mbx_irq;
        s[ST_IN_IRQ]  = q.in_irq;
        s[ST_OUT_IRQ] = q.out_irq;
        return s;
    endfunction

endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = empty ? '0 : mem[rd_ptr];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
    import msgbox_pkg::*;
(
    input  fifo_flags_t      flags,
    input  logic [REG_W-1:0] ctrl,
    input  logic             mbx_pending,
    output irq_flags_t       irq_flags,
    output logic             irq
);

    logic in_en, out_en, mbx_en;

    assign in_en  = ctrl[CT_IN_EN]  | ctrl[CT_IN_WEN];
    assign out_en = ctrl[CT_OUT_EN] | ctrl[CT_OUT_WEN];
    assign mbx_en = ctrl[CT_MBX_EN];

    always_comb begin
        irq_flags.in_irq  = flags.in_nf  & in_en;
        irq_flags.out_irq = flags.out_ne & out_en;
        irq_flags.mbx_irq = mbx_pending  & mbx_en;
    end

    assign irq = |irq_flags;

endmodule

// File: rtl/msg_mailbox.sv
module msg_mailbox
    import msgbox_pkg::*;
#(
    parameter int FIFO_DEPTH = 2,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [1:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    input  logic        cp_in_pop,
    output logic [31:0] cp_in_data,
    input  logic        cp_out_push,
    input  logic [31:0] cp_out_data,
    input  logic        cp_mbx_wr,
    input  logic [31:0] cp_mbx_data,
    output logic        irq
);

    reg_sel_e         sel;
    logic             host_push, host_pop;
    logic [CNT_W-1:0] in_cnt, out_cnt;
    logic             in_empty, in_full, out_empty, out_full;
    logic [REG_W-1:0] out_head;
    logic [REG_W-1:0] ctrl_q, mbx_q;
    fifo_flags_t      flags;
    irq_flags_t       irq_flags;

    assign sel       = reg_sel_e'(host_addr);
    assign host_push = host_wr && (sel == SEL_FIFO);
    assign host_pop  = host_rd && (sel == SEL_FIFO);

    mbx_fifo #(.WIDTH(REG_W), .DEPTH(FIFO_DEPTH)) u_in_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (host_push),
        .push_data (host_wdata),
        .pop       (cp_in_pop),
        .head      (cp_in_data),
        .count     (in_cnt),
        .empty     (in_empty),
        .full      (in_full)
    );

    mbx_fifo #(.WIDTH(REG_W), .DEPTH(FIFO_DEPTH)) u_out_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (cp_out_push),
        .push_data (cp_out_data),
        .pop       (host_pop),
        .head      (out_head),
        .count     (out_cnt),
        .empty     (out_empty),
        .full      (out_full)
    );

    always_comb begin
        flags.out_ne = !out_empty;
        flags.in_nf  = !in_full;
        flags.out_nf = !out_full;
        flags.in_ne  = !in_empty;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (host_wr && sel == SEL_CTRL) begin
            ctrl_q <= host_wdata & CTRL_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mbx_q <= '0;
        end else if (cp_mbx_wr) begin
            mbx_q <= cp_mbx_data;
        end else if (host_wr && sel == SEL_MBX && host_wdata == MBX_CLEAR_KEY) begin
            mbx_q <= '0;
        end
    end

    mbx_irq u_irq (
        .flags       (flags),
        .ctrl        (ctrl_q),
        .mbx_pending (mbx_q != '0),
        .irq_flags   (irq_flags),
        .irq         (irq)
    );

    always_comb begin
        case (sel)
            SEL_FIFO: host_rdata = out_head;
            SEL_STAT: host_rdata = pack_status(flags, irq_flags);
            SEL_CTRL: host_rdata = ctrl_q;
            default:  host_rdata = mbx_q;
        endcase
    end

endmodule

// File: rtl/msg_mailbox_chk.sv
module msg_mailbox_chk #(
    parameter int DEPTH = 2,
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             host_wr,
    input logic             host_rd,
    input logic [1:0]       host_addr,
    input logic [31:0]      host_wdata,
    input logic             cp_in_pop,
    input logic             cp_out_push,
    input logic             cp_mbx_wr,
    input logic [31:0]      cp_in_data,
    input logic             irq,
    input logic [CNT_W-1:0] in_cnt,
    input logic [CNT_W-1:0] out_cnt,
    input logic [31:0]      ctrl_q,
    input logic [31:0]      mbx_q
);

    // R4
    in_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (in_cnt <= CNT_W'(DEPTH)) && (out_cnt <= CNT_W'(DEPTH)));

    // R4
    full_push_chk: assert property (@(posedge clk) disable iff (rst)
        (in_cnt == CNT_W'(DEPTH) && host_wr && host_addr == 2'd0 && !cp_in_pop)
        |=> $stable(in_cnt));

    // R3
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (out_cnt == '0 && host_rd && host_addr == 2'd0 && !cp_out_push)
        |=> (out_cnt == '0));

    // R2
    empty_head_chk: assert property (@(posedge clk) disable iff (rst)
        (in_cnt == '0) |-> (cp_in_data == 32'd0));

    // R9
    mbx_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == 2'd3 && host_wdata == 32'h0000_F0F0 && !cp_mbx_wr)
        |=> (mbx_q == 32'd0));

    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((ctrl_q & 32'h0313_0000) != 32'd0));

endmodule

bind msg_mailbox msg_mailbox_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .cp_in_pop   (cp_in_pop),
    .cp_out_push (cp_out_push),
    .cp_mbx_wr   (cp_mbx_wr),
    .cp_in_data  (cp_in_data),
    .irq         (irq),
    .in_cnt      (in_cnt),
    .out_cnt     (out_cnt),
    .ctrl_q      (ctrl_q),
    .mbx_q       (mbx_q)
);

// File: tb/msg_mailbox_bench.sv
module msg_mailbox_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 2;
    localparam logic [31:0] KEY  = 32'h0000_F0F0;
    localparam logic [31:0] MASK = 32'h0313_0000;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_wr, host_rd;
    logic [1:0]  host_addr;
    logic [31:0] host_wdata, host_rdata;
    logic        cp_in_pop;
    logic [31:0] cp_in_data;
    logic        cp_out_push;
    logic [31:0] cp_out_data;
    logic        cp_mbx_wr;
    logic [31:0] cp_mbx_data;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] in_q[$];
    logic [31:0] out_q[$];
    logic [31:0] m_ctrl, m_mbx;
    logic [31:0] s_rdata, s_cpin;
    logic        s_irq;

    always #(CLK_PERIOD / 2) clk = ~clk;

    msg_mailbox #(.FIFO_DEPTH(DEPTH)) u_msg_mailbox (
        .clk         (clk),
        .rst         (rst),
        .host_wr     (host_wr),
        .host_rd     (host_rd),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .cp_in_pop   (cp_in_pop),
        .cp_in_data  (cp_in_data),
        .cp_out_push (cp_out_push),
        .cp_out_data (cp_out_data),
        .cp_mbx_wr   (cp_mbx_wr),
        .cp_mbx_data (cp_mbx_data),
        .irq         (irq)
    );

    function automatic logic [31:0] exp_status();
        logic [31:0] s;
        s = '0;
        s[16] = out_q.size() != 0;
        s[17] = in_q.size() < DEPTH;
        s[18] = out_q.size() < DEPTH;
        s[19] = in_q.size() != 0;
        s[20] = (m_mbx != 0) && m_ctrl[20];
        s[21] = s[17] && (m_ctrl[17] || m_ctrl[25]);
        s[22] = s[16] && (m_ctrl[16] || m_ctrl[24]);
        return s;
    endfunction

    function automatic logic [31:0] exp_reg(input logic [1:0] a);
        case (a)
            2'd0:    return (out_q.size() != 0) ? out_q[0] : 32'd0;
            2'd1:    return exp_status();
            2'd2:    return m_ctrl;
            default: return m_mbx;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic step(input logic hw, input logic hr, input logic [1:0] a,
                        input logic [31:0] wd, input logic ipop, input logic opush,
                        input logic [31:0] od, input logic mw, input logic [31:0] md);
        int  in_sz, out_sz;
        logic [31:0] st;
        @(negedge clk);
        host_wr = hw; host_rd = hr; host_addr = a; host_wdata = wd;
        cp_in_pop = ipop; cp_out_push = opush; cp_out_data = od;
        cp_mbx_wr = mw; cp_mbx_data = md;
        #1;
        s_rdata = host_rdata; s_cpin = cp_in_data; s_irq = irq;
        st = exp_status();
        check("R2 cp_in_data", cp_in_data, (in_q.size() != 0) ? in_q[0] : 32'd0);
        check("R8 irq", {31'd0, irq}, {31'd0, |st[22:20]});
        if (hr) begin
            case (a)
                2'd0:    check("R3 fifo read", host_rdata, exp_reg(a));
                2'd1:    check("R5 status read", host_rdata, exp_reg(a));
                2'd2:    check("R7 control read", host_rdata, exp_reg(a));
                default: check("R9 mailbox read", host_rdata, exp_reg(a));
            endcase
        end
        @(posedge clk);
        in_sz  = in_q.size();
        out_sz = out_q.size();
        if (ipop && in_sz > 0) in_q.delete(0);
        if (hw && a == 2'd0 && in_sz < DEPTH) in_q.push_back(wd);
        if (hr && a == 2'd0 && out_sz > 0) out_q.delete(0);
        if (opush && out_sz < DEPTH) out_q.push_back(od);
        if (hw && a == 2'd2) m_ctrl = wd & MASK;
        if (mw) m_mbx = md;
        else if (hw && a == 2'd3 && wd == KEY) m_mbx = 32'd0;
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 2'd0, 32'd0, 1'b0, 1'b0, 32'd0, 1'b0, 32'd0);
    endtask

    task automatic hwrite(input logic [1:0] a, input logic [31:0] d);
        step(1'b1, 1'b0, a, d, 1'b0, 1'b0, 32'd0, 1'b0, 32'd0);
    endtask

    task automatic hread(input logic [1:0] a);
        step(1'b0, 1'b1, a, 32'd0, 1'b0, 1'b0, 32'd0, 1'b0, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20455));
        rst = 1'b1;
        host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0;
        cp_in_pop = 0; cp_out_push = 0; cp_out_data = 0; cp_mbx_wr = 0; cp_mbx_data = 0;
        m_ctrl = 0; m_mbx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        hread(2'd1); check("R1 status", s_rdata, 32'h0006_0000);
        check("R1 irq", {31'd0, s_irq}, 32'd0);
        hread(2'd2); check("R1 control", s_rdata, 32'd0);
        hread(2'd3); check("R1 mailbox", s_rdata, 32'd0);
        hread(2'd0); check("R1 empty fifo", s_rdata, 32'd0);

        // R10 two-word loopback, R4 overflow dropped
        hwrite(2'd0, 32'hA1A1_0001);
        hread(2'd1); check("R5 one word", s_rdata, 32'h0006_0000 | 32'h0008_0000);
        hwrite(2'd0, 32'hB2B2_0002);
        hwrite(2'd0, 32'hC3C3_0003);
        hread(2'd1); check("R4 inbound full", s_rdata, 32'h000C_0000);
        step(1'b0, 1'b0, 2'd0, 0, 1'b1, 1'b0, 0, 1'b0, 0);
        check("R10 first word", s_cpin, 32'hA1A1_0001);
        step(1'b0, 1'b0, 2'd0, 0, 1'b1, 1'b1, 32'hA1A1_0001, 1'b0, 0);
        check("R10 second word", s_cpin, 32'hB2B2_0002);
        step(1'b0, 1'b0, 2'd0, 0, 1'b0, 1'b1, 32'hB2B2_0002, 1'b0, 0);
        check("R4 overflow dropped", s_cpin, 32'd0);
        hread(2'd1); check("R5 outbound full", s_rdata, 32'h0003_0000);
        hread(2'd0); check("R10 reply 0", s_rdata, 32'hA1A1_0001);
        hread(2'd0); check("R10 reply 1", s_rdata, 32'hB2B2_0002);

        // R4 same-cycle push/pop on full and empty inbound
        hwrite(2'd0, 32'h1111_1111);
        hwrite(2'd0, 32'h2222_2222);
        step(1'b1, 1'b0, 2'd0, 32'h3333_3333, 1'b1, 1'b0, 0, 1'b0, 0);
        check("R4 full pop head", s_cpin, 32'h1111_1111);
        step(1'b0, 1'b0, 2'd0, 0, 1'b1, 1'b0, 0, 1'b0, 0);
        check("R4 full push dropped", s_cpin, 32'h2222_2222);
        step(1'b1, 1'b0, 2'd0, 32'h4444_4444, 1'b1, 1'b0, 0, 1'b0, 0);
        check("R4 empty pop zero", s_cpin, 32'd0);
        step(1'b0, 1'b0, 2'd0, 0, 1'b1, 1'b0, 0, 1'b0, 0);
        check("R4 empty push kept", s_cpin, 32'h4444_4444);
        // outbound: host pop on empty with coprocessor push
        step(1'b0, 1'b1, 2'd0, 0, 1'b0, 1'b1, 32'h5555_5555, 1'b0, 0);
        check("R4 outbound empty pop", s_rdata, 32'd0);
        hread(2'd0); check("R4 outbound push kept", s_rdata, 32'h5555_5555);

        // R7 / R6 / R8
        hwrite(2'd2, 32'hFFFF_FFFF);
        hread(2'd2); check("R7 control mask", s_rdata, 32'h0313_0000);
        hread(2'd1); check("R6 inbound irq flag", s_rdata, 32'h0026_0000);
        check("R8 irq high", {31'd0, s_irq}, 32'd1);
        hwrite(2'd2, 32'h0000_0000);
        idle(); check("R8 irq low", {31'd0, s_irq}, 32'd0);

        // R9 mailbox
        step(1'b0, 1'b0, 2'd0, 0, 1'b0, 1'b0, 0, 1'b1, 32'h0000_0055);
        hwrite(2'd3, 32'h0000_1234);
        hread(2'd3); check("R9 non-key ignored", s_rdata, 32'h0000_0055);
        step(1'b1, 1'b0, 2'd3, KEY, 1'b0, 1'b0, 0, 1'b1, 32'h0000_0077);
        hread(2'd3); check("R9 cp write wins", s_rdata, 32'h0000_0077);
        hwrite(2'd2, 32'h0010_0000);
        hread(2'd1); check("R6 mailbox irq flag", s_rdata, 32'h0016_0000);
        hwrite(2'd3, KEY);
        hread(2'd3); check("R9 key clears", s_rdata, 32'd0);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] op;
            logic [1:0] a;
            logic [31:0] d;
            op = 4'($urandom_range(0, 9));
            a  = 2'($urandom_range(0, 3));
            d  = $urandom();
            if (a == 2'd3 && op[0]) d = KEY;
            if (op < 4)
                step(1'b1, 1'b0, (op < 2) ? 2'd0 : a, d, 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)), $urandom(), 1'($urandom_range(0, 7) == 0), $urandom());
            else if (op < 8)
                step(1'b0, 1'b1, (op < 6) ? 2'd0 : a, 0, 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)), $urandom(), 1'($urandom_range(0, 7) == 0), $urandom());
            else
                step(1'b0, 1'b0, 2'd0, 0, 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)), $urandom(), 1'b0, 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule